// File: doc/BRIEF.md
# Prioritised Interrupt Router

This block gathers level-sensitive interrupt requests from a set of numbered sources and hands each one to one or more targets (contexts). Every source has a programmable priority. Every context has its own enable mask and its own threshold. A context's interrupt line rises when an enabled, pending source outranks that context's threshold. Software running on the target reads the context's claim word to learn which source to service. It writes the same source number back to that word when the handler is done.

Contexts are numbered so that context 2h is the machine-level target of hart h and context 2h+1 is its supervisor-level target. The block does not map harts itself. All state sits behind a flat 32-bit register port, with a single-cycle access when `bus_sel` is high. Read data is combinational from the current state, and a write or the side effect of a claim read takes place at the clock edge that ends the access.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, all priorities, enables, thresholds and pending bits are zero. Every `irq_out` bit is low, and a claim read returns 0.
- R2: The priority of source s is a word at byte offset 4*s. Only the low PRIO_W bits are stored and read back, the upper bits read as zero, and source 0 always reads 0.
- R3: A source whose input is high becomes pending at the next clock edge. Pending bit s is readable at offset 0x1000 + 4*(s/32), bit s%32. Source 0 is never pending.
- R4: The enable bit of source s for context c is at offset 0x2000 + 0x80*c + 4*(s/32), bit s%32. Each context keeps its own mask, and bit 0 always reads 0.
- R5: The threshold of context c is at offset 0x200000 + 0x1000*c. `irq_out[c]` is high exactly when the best pending enabled source has a priority strictly above that threshold.
- R6: A read of the claim word at 0x200004 + 0x1000*c returns the highest-priority pending source enabled for c. Equal priorities go to the lowest source number. The read returns 0 when no such source exists, and the threshold has no influence on the result.
- R7: A claim read that returns a nonzero ID clears that source's pending bit at the end of the same access. The source is not pended again by its input until it is completed.
- R8: Writing an ID to the claim word of context c completes that source only if it is enabled for c. The ID need not match the last ID claimed by c. A write of an ID that is not enabled for c changes nothing.
- R9: A write to a pending word sets or clears the pending bits of the sources it covers, and this write takes precedence over the input lines.
- R10: A source with priority 0 is never returned by a claim and never raises `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_lvl | input | NSRC | Level request per source; bit 0 is unused |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| irq_out | output | NCTX | Interrupt request per context |

## Verification
The selection logic is exercised through a table of rows. Each row programs pending bits, an enable mask and a threshold against a fixed set of priorities. The rows separate priority ordering, lowest-ID tie breaking, masking by the enables, a claim that ignores the threshold, the strict comparison of priority against threshold, and priority-zero exclusion. Directed sequences then drive real input lines across both contexts. They show that a claim from one context retires the source while the line stays high, that a completion from a context without the enable is dropped, and that a completion from a different context than the claimer releases the source.

// File: rtl/irq_router_pkg.sv
// Package: shared register-region codes and address map constants.
// Assumes byte addressing and 32-bit register words.
package irq_router_pkg;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_PRIO,
        RGN_PEND,
        RGN_ENAB,
        RGN_THRESH,
        RGN_CLAIM
    } rgn_e;

    localparam int unsigned PEND_BASE   = 32'h0000_1000;
    localparam int unsigned ENAB_BASE   = 32'h0000_2000;
    localparam int unsigned CTX_BASE    = 32'h0020_0000;
    localparam int unsigned ENAB_STRIDE = 7;   // log2 of 0x80 bytes per context
    localparam int unsigned CTX_STRIDE  = 12;  // log2 of 0x1000 bytes per context

endpackage

// File: rtl/irq_router_decode.sv
// Address decoder: classifies a byte address into a register region and
// extracts the source, word and context indices. Unaligned or
// out-of-range addresses decode to RGN_NONE.
module irq_router_decode #(
    parameter int NSRC   = 8,
    parameter int NCTX   = 2,
    parameter int ADDR_W = 26,
    localparam int ID_W   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int NWORD  = (NSRC + 31) / 32,
    localparam int WORD_W = (NWORD > 1) ? $clog2(NWORD) : 1,
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [ADDR_W-1:0]           addr,
    output irq_router_pkg::rgn_e        rgn,
    output logic [ID_W-1:0]             src_idx,
    output logic [WORD_W-1:0]           word_idx,
    output logic [CTX_W-1:0]            ctx_idx
);
    import irq_router_pkg::*;

    logic [31:0] a32;
    logic [31:0] off;

    assign a32 = 32'(addr);

    // Region and index extraction.
    always_comb begin
        rgn      = RGN_NONE;
        src_idx  = '0;
        word_idx = '0;
        ctx_idx  = '0;
        off      = '0;
        if (a32[1:0] != 2'b00) begin
            rgn = RGN_NONE;
        end else if (a32 < PEND_BASE) begin
            if ((a32 >> 2) < 32'(NSRC)) begin
                rgn     = RGN_PRIO;
                src_idx = ID_W'(a32 >> 2);
            end
        end else if (a32 < ENAB_BASE) begin
            off = a32 - PEND_BASE;
            if ((off >> 2) < 32'(NWORD)) begin
                rgn      = RGN_PEND;
                word_idx = WORD_W'(off >> 2);
            end
        end else if (a32 < CTX_BASE) begin
            off = a32 - ENAB_BASE;
            if ((off >> ENAB_STRIDE) < 32'(NCTX) && (off[6:0] >> 2) < 32'(NWORD)) begin
                rgn      = RGN_ENAB;
                ctx_idx  = CTX_W'(off >> ENAB_STRIDE);
                word_idx = WORD_W'(off[6:0] >> 2);
            end
        end else begin
            off = a32 - CTX_BASE;
            if ((off >> CTX_STRIDE) < 32'(NCTX)) begin
                ctx_idx = CTX_W'(off >> CTX_STRIDE);
                if (off[11:0] == 12'h000)      rgn = RGN_THRESH;
                else if (off[11:0] == 12'h004) rgn = RGN_CLAIM;
            end
        end
    end

endmodule

// File: rtl/irq_router_gate.sv
// Per-source request gate: holds the pending and in-service flags.
// Assumes claim, software write and level are mutually prioritised
// claim > software write > level; a source in service ignores its level.
module irq_router_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic claim_hit,
    input  logic done_hit,
    input  logic sw_wr,
    input  logic sw_val,
    output logic pend,
    output logic busy
);

    // Pending flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (claim_hit)  pend <= 1'b0;
        else if (sw_wr)      pend <= sw_val;
        else if (lvl && !busy) pend <= 1'b1;
    end

    // In-service flag: set by a claim, cleared by an accepted completion.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy <= 1'b0;
        else if (claim_hit) busy <= 1'b1;
        else if (done_hit)  busy <= 1'b0;
    end

endmodule

// File: rtl/irq_router_arbiter.sv
// Per-context selector: finds the pending, enabled source with the highest
// priority (lowest ID on ties) and compares it against the threshold.
// Assumes priority 0 means "never"; source 0 is skipped.
module irq_router_arbiter #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int ID_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]        pend_vec,
    input  logic [NSRC-1:0]        en_vec,
    input  logic [NSRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]      thresh,
    output logic [ID_W-1:0]        best_id,
    output logic [PRIO_W-1:0]      best_prio,
    output logic                   irq
);

    // Linear scan from low IDs; a strict compare keeps the lowest ID on ties.
    always_comb begin
        best_id   = '0;
        best_prio = '0;
        for (int i = 1; i < NSRC; i++) begin
            if (pend_vec[i] && en_vec[i] && (prio_flat[i*PRIO_W +: PRIO_W] > best_prio)) begin
                best_prio = prio_flat[i*PRIO_W +: PRIO_W];
                best_id   = ID_W'(i);
            end
        end
    end

    // Interrupt request when the winner strictly beats the threshold.
    assign irq = (best_prio > thresh);

endmodule

// File: rtl/irq_router.sv
// Top: register file, per-source gates and per-context arbiters.
// Assumes one register access per cycle; a claim read's side effect lands
// at the edge that ends the access.
module irq_router #(
    parameter int NSRC   = 8,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_lvl,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCTX-1:0]   irq_out
);
    import irq_router_pkg::*;

    localparam int ID_W   = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam int NWORD  = (NSRC + 31) / 32;
    localparam int WORD_W = (NWORD > 1) ? $clog2(NWORD) : 1;
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1;

    rgn_e                   rgn;
    logic [ID_W-1:0]        src_idx;
    logic [WORD_W-1:0]      word_idx;
    logic [CTX_W-1:0]       ctx_idx;

    logic [NSRC*PRIO_W-1:0] prio_flat;
    logic [NSRC-1:0]        en_q [NCTX];
    logic [PRIO_W-1:0]      thr_q [NCTX];

    logic [NSRC-1:0]        pend_vec;
    logic [NSRC-1:0]        busy_vec;
    logic [NSRC-1:0]        pend_wr;
    logic [NSRC-1:0]        claim_vec;
    logic [NSRC-1:0]        done_vec;
    logic [NCTX*ID_W-1:0]   best_id_flat;
    logic [ID_W-1:0]        claim_id;
    logic                   claim_fire;
    logic                   wr_en;

    assign wr_en = bus_sel && bus_we;

    irq_router_decode #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) dec_i (
        .addr     (bus_addr),
        .rgn      (rgn),
        .src_idx  (src_idx),
        .word_idx (word_idx),
        .ctx_idx  (ctx_idx)
    );

    // Priority, enable and threshold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_flat <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (wr_en) begin
            case (rgn)
                RGN_PRIO: begin
                    if (src_idx != '0)
                        prio_flat[src_idx*PRIO_W +: PRIO_W] <= bus_wdata[PRIO_W-1:0];
                end
                RGN_ENAB: begin
                    for (int b = 0; b < 32; b++) begin
                        if ((32'(word_idx) * 32 + b) < NSRC && (32'(word_idx) * 32 + b) != 0)
                            en_q[ctx_idx][32'(word_idx) * 32 + b] <= bus_wdata[b];
                    end
                end
                RGN_THRESH: thr_q[ctx_idx] <= bus_wdata[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // Claim: a read of the claim word with a nonzero winner.
    assign claim_id   = best_id_flat[ctx_idx*ID_W +: ID_W];
    assign claim_fire = bus_sel && !bus_we && (rgn == RGN_CLAIM) && (claim_id != '0);

    // Per-source gates; source 0 is tied off.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s == 0) begin : g_rsv
            assign pend_vec[s]  = 1'b0;
            assign busy_vec[s]  = 1'b0;
            assign pend_wr[s]   = 1'b0;
            assign claim_vec[s] = 1'b0;
            assign done_vec[s]  = 1'b0;
        end else begin : g_gate
            assign pend_wr[s]   = wr_en && (rgn == RGN_PEND) && (32'(word_idx) == s / 32);
            assign claim_vec[s] = claim_fire && (claim_id == ID_W'(s));
            assign done_vec[s]  = wr_en && (rgn == RGN_CLAIM) && (bus_wdata == 32'(s))
                                  && en_q[ctx_idx][s];
            irq_router_gate gate_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .lvl       (src_lvl[s]),
                .claim_hit (claim_vec[s]),
                .done_hit  (done_vec[s]),
                .sw_wr     (pend_wr[s]),
                .sw_val    (bus_wdata[s % 32]),
                .pend      (pend_vec[s]),
                .busy      (busy_vec[s])
            );
        end
    end

    // Per-context arbiters.
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        logic [PRIO_W-1:0] best_prio;
        irq_router_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) arb_i (
            .pend_vec  (pend_vec),
            .en_vec    (en_q[c]),
            .prio_flat (prio_flat),
            .thresh    (thr_q[c]),
            .best_id   (best_id_flat[c*ID_W +: ID_W]),
            .best_prio (best_prio),
            .irq       (irq_out[c])
        );
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (rgn)
            RGN_PRIO:   bus_rdata = 32'(prio_flat[src_idx*PRIO_W +: PRIO_W]);
            RGN_PEND: begin
                for (int b = 0; b < 32; b++)
                    if ((32'(word_idx) * 32 + b) < NSRC)
                        bus_rdata[b] = pend_vec[32'(word_idx) * 32 + b];
            end
            RGN_ENAB: begin
                for (int b = 0; b < 32; b++)
                    if ((32'(word_idx) * 32 + b) < NSRC)
                        bus_rdata[b] = en_q[ctx_idx][32'(word_idx) * 32 + b];
            end
            RGN_THRESH: bus_rdata = 32'(thr_q[ctx_idx]);
            RGN_CLAIM:  bus_rdata = 32'(claim_id);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_router_chk.sv
// Checker: temporal properties on gate state, arbiter results and outputs.
module irq_router_chk #(
    parameter int NSRC = 8,
    parameter int NCTX = 2,
    localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCTX-1:0]      irq_out,
    input logic [NSRC-1:0]      pend_vec,
    input logic [NSRC-1:0]      busy_vec,
    input logic [NSRC-1:0]      pend_wr,
    input logic [NCTX*ID_W-1:0] best_id_flat,
    input logic                 claim_fire,
    input logic [ID_W-1:0]      claim_id
);
    logic            was_rst;
    logic            last_fire;
    logic [ID_W-1:0] last_id;

    // Remember reset and the previous claim.
    always_ff @(posedge clk) begin
        was_rst   <= !rst_n;
        last_fire <= rst_n && claim_fire;
        last_id   <= claim_id;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (irq_out == '0)); // R1

    AST_SRC0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vec[0] && !busy_vec[0]); // R3

    AST_CLAIM_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        last_fire |-> (!pend_vec[last_id] && busy_vec[last_id])); // R7

    for (genvar c = 0; c < NCTX; c++) begin : g_c
        AST_IRQ_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[c] |-> (best_id_flat[c*ID_W +: ID_W] != '0)); // R5
    end

    for (genvar s = 1; s < NSRC; s++) begin : g_s
        AST_NO_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend_vec[s]) |-> ($past(pend_wr[s]) || !$past(busy_vec[s]))); // R7
    end

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCTX(NCTX)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_out      (irq_out),
    .pend_vec     (pend_vec),
    .busy_vec     (busy_vec),
    .pend_wr      (pend_wr),
    .best_id_flat (best_id_flat),
    .claim_fire   (claim_fire),
    .claim_id     (claim_id)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int NCTX = 2;
    localparam int ADDR_W = 26;

    localparam logic [ADDR_W-1:0] A_PEND = 26'h000_1000;

    // Row: pend[39:32] en[31:24] thresh[23:16] exp_id[15:8] exp_irq[7:0]
    // Priorities: s1=2 s2=5 s3=5 s4=0 s5=7 s6=3 s7=1
    localparam logic [39:0] VEC [9] = '{
        40'h06_FE_00_02_01,  // R6 highest wins
        40'h0C_FE_00_02_01,  // R6 tie -> lowest ID
        40'h0C_FA_00_03_01,  // R6 disabled source skipped
        40'h26_FE_06_05_01,  // R5 7 > 6
        40'h26_FE_07_05_00,  // R6 claim ignores threshold, R5 7 !> 7
        40'h10_FE_00_00_00,  // R10 priority 0 never selected
        40'h42_FE_03_06_00,  // R5 strict compare 3 !> 3
        40'h80_00_00_00_00,  // R6 nothing enabled -> 0
        40'h01_FE_00_00_00   // R3 source 0 never pends
    };
    localparam logic [31:0] PRIOS [8] = '{0, 2, 5, 5, 0, 7, 3, 1};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   src_lvl = '0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCTX-1:0]   irq_out;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    function automatic logic [ADDR_W-1:0] a_prio(int s);   return ADDR_W'(4 * s); endfunction
    function automatic logic [ADDR_W-1:0] a_en(int c);     return ADDR_W'(32'h2000 + 32'h80 * c); endfunction
    function automatic logic [ADDR_W-1:0] a_thr(int c);    return ADDR_W'(32'h20_0000 + 32'h1000 * c); endfunction
    function automatic logic [ADDR_W-1:0] a_claim(int c);  return ADDR_W'(32'h20_0004 + 32'h1000 * c); endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 irq_out", 32'(irq_out), 0);
        rd(a_claim(0), d); check("R1 claim", d, 0);
        rd(a_prio(5), d);  check("R1 prio", d, 0);
        rd(A_PEND, d);     check("R1 pend", d, 0);
        rd(a_thr(1), d);   check("R1 thresh", d, 0);

        // R2 priority storage width and source 0
        wr(a_prio(6), 32'hFFFF_FFFF);
        rd(a_prio(6), d); check("R2 prio width", d, 32'h7);
        wr(a_prio(0), 32'h5);
        rd(a_prio(0), d); check("R2 source 0", d, 0);

        // R4 per-context enables, bit 0 fixed
        wr(a_en(1), 32'hA5);
        rd(a_en(1), d); check("R4 ctx1 enable", d, 32'hA4);
        rd(a_en(0), d); check("R4 ctx0 untouched", d, 0);
        wr(a_en(1), 32'h0);

        for (int s = 1; s < NSRC; s++) wr(a_prio(s), PRIOS[s]);

        // Table of selection rows on context 0
        for (int r = 0; r < 9; r++) begin
            wr(A_PEND, 32'(VEC[r][39:32]));
            wr(a_en(0), 32'(VEC[r][31:24]));
            wr(a_thr(0), 32'(VEC[r][23:16]));
            rd(A_PEND, d); check("R9 pend write", d, 32'(VEC[r][39:32] & 8'hFE));
            check("R5 irq row", 32'(irq_out[0]), 32'(VEC[r][7:0]));
            rd(a_claim(0), d); check("R6 claim row", d, 32'(VEC[r][15:8]));
            if (VEC[r][15:8] != 0) begin
                rd(A_PEND, d);
                check("R7 claimed cleared", d[VEC[r][10:8]], 0);
                wr(a_claim(0), 32'(VEC[r][15:8]));
            end
            wr(A_PEND, 32'h0);
        end
        wr(a_thr(0), 0);

        // R3 level inputs
        src_lvl = 8'h21;
        idle(2);
        rd(A_PEND, d); check("R3 level pends, src0 ignored", d, 32'h20);

        // R5/R6 on context 1
        wr(a_en(0), 32'h0);
        wr(a_en(1), 32'h20);
        check("R5 ctx1 irq", 32'(irq_out), 32'h2);
        rd(a_claim(1), d); check("R6 ctx1 claim", d, 5);
        idle(3);
        rd(A_PEND, d); check("R7 no repend while line high", d, 0);

        // R8 completion not enabled for ctx0 is dropped
        wr(a_claim(0), 5);
        idle(3);
        rd(A_PEND, d); check("R8 ignored completion", d, 0);

        // R8 completion from ctx0 (not the claimer) once enabled
        wr(a_en(0), 32'h20);
        wr(a_claim(0), 5);
        idle(1);
        rd(A_PEND, d); check("R8 completion releases", d, 32'h20);

        // R9 software clear overrides the line
        wr(A_PEND, 32'h0);
        rd(A_PEND, d); check("R9 software clear", d, 0);
        src_lvl = '0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule